// File: doc/BRIEF.md
# Binary to Residue Converter

This block turns a 24-bit binary sample into its residue-number form over four moduli: 2^15, 2^15−1, 2^14−1 and 2^13−1. These are pairwise coprime and together span more than 56 bits, so one full sample is always represented without loss. Each accepted word produces four residues on separate output fields, ready for independent narrow modular datapaths.

A per-sample flag selects whether the word is read as unsigned or as two's-complement signed. The power-of-two residue is the low 15 bits of the word. For the three moduli of the form 2^k−1, the block does the following:

- It takes the magnitude of the word.
- It folds the magnitude by adding its upper part, shifted down by k, back onto its low k bits, and repeats this until k+1 bits remain.
- It corrects the result with a single conditional subtract, so the all-ones pattern becomes zero.
- For a negative sample, it replaces the residue with its k-bit one's complement, which is the additive inverse.

No divider is used. The pipeline takes a new sample every cycle. Results appear three cycles after acceptance.

Top module: `rns_fwd_conv`

## Requirements
- R1: `res_p2` equals bits [14:0] of the accepted word in both signed and unsigned mode. For a negative sample this is the two's-complement low part, which is already the correct residue modulo 2^15.
- R2: With `in_signed`=0, the word is an unsigned value X in [0, 2^24). `res_a`, `res_b` and `res_c` equal X mod 32767, X mod 16383 and X mod 8191 respectively.
- R3: With `in_signed`=1, the word is a signed value X in [−2^23, 2^23). Each of `res_a`, `res_b` and `res_c` equals the non-negative remainder ((X mod m)+m) mod m.
- R4: Every 2^k−1 residue is strictly below its modulus. A value congruent to zero is given as 0, never as all ones. This holds both for a positive multiple of the modulus and for a negated multiple.
- R5: A word is accepted in a cycle where `in_valid` and `in_ready` are both high. Its residues are presented with `out_valid` high exactly 3 cycles later. `out_valid` is otherwise low.
- R6: Back-to-back samples on consecutive cycles yield results on consecutive cycles, in arrival order. Gaps in the input appear as gaps in the output.
- R7: While `rst` is high, `out_valid` and `in_ready` are low. From the first cycle after reset is released, `in_ready` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block accepts a word (high whenever out of reset) |
| in_data | input | 24 | Binary sample |
| in_signed | input | 1 | 1: sample is two's-complement signed, 0: unsigned |
| out_valid | output | 1 | Residue fields are valid |
| res_p2 | output | 15 | Residue modulo 2^15 |
| res_a | output | 15 | Residue modulo 2^15−1 |
| res_b | output | 14 | Residue modulo 2^14−1 |
| res_c | output | 13 | Residue modulo 2^13−1 |

## Verification
Two operations can fall in the same cycle within one lane: the final correction that maps a folded value equal to the modulus down to zero, and the sign inversion of that residue. If the block got this wrong, it would emit all ones. The bench provokes this by feeding negated exact multiples of each modulus (for example −32767, −16383 and −8191), as well as the most negative word −2^23. It also feeds unsigned all-ones words whose folds land exactly on the modulus. The scoreboard judges each case against a remainder computed with ordinary integer arithmetic, and demands 0 where that remainder is 0.

// File: rtl/rns_pkg.sv
package rns_pkg;
  // number of end-around fold passes needed to bring a w-bit value to k+1 bits
  function automatic int unsigned fold_passes(input int unsigned w, input int unsigned k);
    return (w + k - 1) / k + 1;
  endfunction
endpackage

// File: rtl/rns_front.sv
// Stage 1: capture word, derive sign flag and magnitude.
module rns_front #(
  parameter int unsigned W = 24,
  parameter int unsigned N = 15
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  input  logic         dsigned,
  output logic [W-1:0] mag_q,
  output logic         neg_q,
  output logic [N-1:0] low_q
);
  logic         neg_d;
  logic [W-1:0] mag_d;

  always_comb begin
    neg_d = dsigned & din[W-1];
    mag_d = neg_d ? (~din + 1'b1) : din;
  end

  always_ff @(posedge clk) begin
    mag_q <= mag_d;
    neg_q <= neg_d;
    low_q <= din[N-1:0];
  end
endmodule

// File: rtl/rns_mersenne_lane.sv
// Stages 2 and 3 for one modulus 2^K-1: fold, then correct and invert.
module rns_mersenne_lane #(
  parameter int unsigned W = 24,
  parameter int unsigned K = 15
) (
  input  logic         clk,
  input  logic [W-1:0] mag,
  input  logic         neg,
  output logic [K-1:0] res_q
);
  import rns_pkg::*;

  localparam int unsigned NPASS = fold_passes(W, K);
  localparam logic [W:0]   LOWMASK = (W+1)'((1 << K) - 1);
  localparam logic [K:0]   MODV    = (K+1)'((1 << K) - 1);

  logic [K:0]   fold_d, fold_q;
  logic         neg_q;
  logic [K:0]   corr;
  logic [K-1:0] res_d;

  always_comb begin
    logic [W:0] v;
    v = {1'b0, mag};
    for (int i = 0; i < NPASS; i++) begin
      v = (v & LOWMASK) + (v >> K);
    end
    fold_d = v[K:0];
  end

  always_ff @(posedge clk) begin
    fold_q <= fold_d;
    neg_q  <= neg;
  end

  always_comb begin
    corr = (fold_q >= MODV) ? (fold_q - MODV) : fold_q;
    if (neg_q && (corr != '0)) res_d = ~corr[K-1:0];
    else                       res_d = corr[K-1:0];
  end

  always_ff @(posedge clk) res_q <= res_d;
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv #(
  parameter int unsigned W = 24,
  parameter int unsigned N = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  input  logic           in_signed,
  output logic           out_valid,
  output logic [N-1:0]   res_p2,
  output logic [N-1:0]   res_a,
  output logic [N-2:0]   res_b,
  output logic [N-3:0]   res_c
);
  localparam int unsigned LAT = 3;

  logic [W-1:0] mag;
  logic         neg;
  logic [N-1:0] low1, low2;
  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready <= 1'b0;
      vpipe    <= '0;
    end else begin
      in_ready <= 1'b1;
      vpipe    <= {vpipe[LAT-2:0], in_valid & in_ready};
    end
  end
  assign out_valid = vpipe[LAT-1];

  rns_front #(.W(W), .N(N)) u_front (
    .clk(clk), .din(in_data), .dsigned(in_signed),
    .mag_q(mag), .neg_q(neg), .low_q(low1)
  );

  always_ff @(posedge clk) begin
    low2   <= low1;
    res_p2 <= low2;
  end

  rns_mersenne_lane #(.W(W), .K(N))   u_lane_a (.clk(clk), .mag(mag), .neg(neg), .res_q(res_a));
  rns_mersenne_lane #(.W(W), .K(N-1)) u_lane_b (.clk(clk), .mag(mag), .neg(neg), .res_q(res_b));
  rns_mersenne_lane #(.W(W), .K(N-2)) u_lane_c (.clk(clk), .mag(mag), .neg(neg), .res_q(res_c));
endmodule

// File: rtl/rns_fwd_conv_chk.sv
module rns_fwd_conv_chk #(
  parameter int unsigned W = 24,
  parameter int unsigned N = 15
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [N-1:0] res_p2,
  input logic [N-1:0] res_a,
  input logic [N-2:0] res_b,
  input logic [N-3:0] res_c
);
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid & in_ready, 3));

  assert_low_bits_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> res_p2 == $past(in_data[N-1:0], 3));

  assert_range_a_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> res_a != {N{1'b1}});
  assert_range_b_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> res_b != {(N-1){1'b1}});
  assert_range_c_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> res_c != {(N-2){1'b1}});

  assert_ready_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> in_ready);
endmodule

bind rns_fwd_conv rns_fwd_conv_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .res_p2(res_p2),
  .res_a(res_a), .res_b(res_b), .res_c(res_c)
);

// File: tb/sim_rns_fwd_conv.sv
`timescale 1ns/1ps
module sim_rns_fwd_conv;
  localparam int W = 24;
  localparam int N = 15;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_signed = 0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [N-1:0] res_p2, res_a;
  logic [N-2:0] res_b;
  logic [N-3:0] res_c;

  always #4 clk = ~clk;

  rns_fwd_conv #(.W(W), .N(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_signed(in_signed), .out_valid(out_valid),
    .res_p2(res_p2), .res_a(res_a), .res_b(res_b), .res_c(res_c)
  );

  typedef struct {
    longint p2, a, b, c;
    longint due;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  longint cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint posmod(input longint v, input longint m);
    return ((v % m) + m) % m;
  endfunction

  // drive one sample at a negedge; it is captured at the next posedge
  task automatic send(input logic [W-1:0] d, input logic s);
    exp_t e;
    longint v;
    v = s ? longint'($signed(d)) : longint'(d);
    e.p2 = longint'(d[N-1:0]);
    e.a = posmod(v, 32767);
    e.b = posmod(v, 16383);
    e.c = posmod(v, 8191);
    e.due = cyc + 3;
    q.push_back(e);
    in_valid = 1; in_data = d; in_signed = s;
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        chk("R5 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R5 latency", cyc, e.due);
        chk("R1 res_p2", longint'(res_p2), e.p2);
        chk("R2/R3/R4 res_a", longint'(res_a), e.a);
        chk("R2/R3/R4 res_b", longint'(res_b), e.b);
        chk("R2/R3/R4 res_c", longint'(res_c), e.c);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 out_valid in reset", out_valid, 0);
    chk("R7 in_ready in reset", in_ready, 0);
    rst = 0;
    @(negedge clk);
    chk("R7 in_ready after reset", in_ready, 1);

    // R2 unsigned patterns
    send(24'd0, 0);
    send(24'd12345, 0);
    send(24'h7FFF, 0);     // R4 multiple of 32767
    send(24'h3FFF, 0);     // R4 multiple of 16383
    send(24'h1FFF, 0);     // R4 multiple of 8191
    send(24'hFFFFFF, 0);   // R2 all ones unsigned
    send(24'h800000, 0);
    // R3 signed patterns
    send(24'hFFFFFF, 1);   // -1
    send(24'h800000, 1);   // most negative
    send(-24'sd32767, 1);  // R4 negated multiple
    send(-24'sd16383, 1);
    send(-24'sd8191, 1);
    send(24'h7FFFFF, 1);
    send(24'd54321, 1);
    repeat (4) @(negedge clk);

    // R6 back-to-back with gaps
    for (int i = 0; i < 60; i++) begin
      send(W'($urandom), 1'($urandom));
      if (i % 7 == 3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R6 queue drained", q.size(), 0);
    chk("R5 idle out_valid", out_valid, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule